// File: doc/BRIEF.md
# TDM Frame Timing Unit

This block takes the raw bit clock and frame-sync pins of a time-division multiplexed serial link and turns them into single-cycle pulses in the system clock domain. It handles the receive and the transmit direction separately. For each direction it produces four outputs: a strobe on which a data bit is to be captured, a strobe on which the next data bit is to be driven, a pulse that marks the first bit of a frame, and the index of the bit within the frame.

The TDM pins are oversampled by the system clock. Edges are found in the synchronised samples. Configuration inputs select the following:
- which clock edge launches data and which samples it,
- which clock edge samples the frame sync,
- the active level of the frame sync,
- a sync-to-first-bit delay of zero to three bits, set per direction,
- a mode in which the TDM clock runs at twice the bit rate,
- the frame length in whole octets,
- a mode in which both directions share the receive pins.

The configuration is meant to be held static while the block runs.

Top module: `tdm_frame_timer`

## Requirements
- R1: While `rst_n` is low, every strobe, every frame-start pulse and both bit counters are 0.
- R2: Each pin passes through two system-clock flops before edge detection. A pin level captured at system clock edge j reaches the outputs registered at edge j+2. With `cfg_launch_on_fall`=0, the launch strobe marks a rising TDM clock edge and the sample strobe marks a falling one. With `cfg_launch_on_fall`=1, the two edges swap. Each strobe lasts one system cycle.
- R3: The frame sync is examined only on the TDM clock edge chosen by `cfg_fs_on_rise` (1 = rising, 0 = falling). It counts as detected when its level on that edge is 1, or 0 when `cfg_fs_active_low`=1.
- R4: After a sync is detected with a delay setting d, the frame-start pulse rises together with the (d+1)-th sample strobe that follows the detection cycle. A sample strobe in the detection cycle itself is not counted. The delays `cfg_rx_fs_delay` and `cfg_tx_fs_delay` are independent.
- R5: The bit counter becomes 0 with the frame-start pulse. On every other sample strobe it increments, and it wraps to 0 after 8*(`cfg_frame_octets_m1`+1)-1. Without a sample strobe it holds its value.
- R6: With `cfg_double_rate`=1, a phase bit toggles on each launch-edge TDM transition and is cleared by a sync detection. Launch strobes occur only on launch edges seen with phase 0. Sample strobes occur only on sample edges seen with phase 1.
- R7: With `cfg_shared_pins`=1, the transmit direction uses the receive clock and sync pins, and `tx_tdm_clk` and `tx_tdm_fs` have no effect on any output.
- R8: A sync detected while an earlier frame start is still pending restarts the delay count, so the earlier start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the TDM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shared_pins | input | 1 | Both directions use the receive pins |
| cfg_launch_on_fall | input | 1 | Launch on falling edge, sample on rising |
| cfg_fs_on_rise | input | 1 | Sample frame sync on rising edge |
| cfg_fs_active_low | input | 1 | Frame sync active level is low |
| cfg_double_rate | input | 1 | TDM clock runs at twice the bit rate |
| cfg_rx_fs_delay | input | 2 | Receive sync-to-first-bit delay in bits |
| cfg_tx_fs_delay | input | 2 | Transmit sync-to-first-bit delay in bits |
| cfg_frame_octets_m1 | input | OCT_W | Frame length in octets minus one |
| rx_tdm_clk | input | 1 | Raw receive TDM clock |
| rx_tdm_fs | input | 1 | Raw receive frame sync |
| tx_tdm_clk | input | 1 | Raw transmit TDM clock |
| tx_tdm_fs | input | 1 | Raw transmit frame sync |
| rx_sample | output | 1 | Receive capture strobe |
| rx_launch | output | 1 | Receive drive strobe |
| rx_frame_start | output | 1 | Receive first-bit pulse |
| rx_bit_cnt | output | OCT_W+3 | Receive bit index |
| tx_sample | output | 1 | Transmit capture strobe |
| tx_launch | output | 1 | Transmit drive strobe |
| tx_frame_start | output | 1 | Transmit first-bit pulse |
| tx_bit_cnt | output | OCT_W+3 | Transmit bit index |

## Verification
The two directions are driven with TDM clocks of different periods, so that a mix-up between the receive and transmit paths shows up at once. The test cases differ in the following ways:
- Edge choice and sync polarity are flipped between cases. This separates launch from sample strobes and rising-edge from falling-edge sync detection.
- Each delay setting from 0 to 3 is used.
- One case sends syncs every third bit against a three-bit delay. This shows whether a pending start is restarted or fires anyway.
- A double-rate case runs with shared pins while the transmit pins toggle noise. It exposes both the phase gating and any leak from the unused pins.
- A 64-octet frame is left to run past its end without a second sync. This shows the wrap point of the counter.

// File: rtl/tdm_ft_pkg.sv
package tdm_ft_pkg;
    localparam int MAX_OCTETS = 64;
    localparam int OCT_W      = $clog2(MAX_OCTETS);
    localparam int DLY_W      = 2;

    typedef struct packed {
        logic launch_fall;
        logic fs_on_rise;
        logic fs_low;
        logic dbl;
    } edge_cfg_t;
endpackage

// File: rtl/tdm_ft_sync.sv
module tdm_ft_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
        logic [W-1:0] old;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = pins;
        s_d.stab = s_q.meta;
        s_d.old  = s_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur  = s_q.stab;
    assign prev = s_q.old;
endmodule

// File: rtl/tdm_ft_dir.sv
module tdm_ft_dir
    import tdm_ft_pkg::*;
#(
    parameter int OCT_W_P = OCT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ck_cur,
    input  logic                 ck_prev,
    input  logic                 fs_lvl,
    input  edge_cfg_t            cfg,
    input  logic [DLY_W-1:0]     delay,
    input  logic [OCT_W_P-1:0]   octets_m1,
    output logic                 sample,
    output logic                 launch,
    output logic                 start,
    output logic [OCT_W_P+2:0]   bit_cnt
);
    localparam int CNT_W = OCT_W_P + 3;

    typedef struct packed {
        logic             half;
        logic             pend;
        logic [DLY_W-1:0] remain;
        logic [CNT_W-1:0] cnt;
        logic             sample;
        logic             launch;
        logic             start;
    } dir_t;

    dir_t st_d, st_q;

    logic             rise, fall, launch_edge, samp_edge, fs_edge, fs_det;
    logic             do_launch, do_samp;
    logic [CNT_W-1:0] last_bit;

    always_comb begin
        rise        = ck_cur & ~ck_prev;
        fall        = ~ck_cur & ck_prev;
        launch_edge = cfg.launch_fall ? fall : rise;
        samp_edge   = cfg.launch_fall ? rise : fall;
        fs_edge     = cfg.fs_on_rise ? rise : fall;
        fs_det      = fs_edge & (fs_lvl ^ cfg.fs_low);
        do_launch   = launch_edge & (~cfg.dbl | ~st_q.half);
        do_samp     = samp_edge & (~cfg.dbl | st_q.half);
        last_bit    = {octets_m1, 3'b111};

        st_d        = st_q;
        st_d.launch = do_launch;
        st_d.sample = do_samp;
        st_d.start  = 1'b0;

        if (cfg.dbl) begin
            if (launch_edge) st_d.half = ~st_q.half;
        end else begin
            st_d.half = 1'b0;
        end

        if (do_samp) begin
            if (st_q.pend && st_q.remain == '0) begin
                st_d.start = 1'b1;
                st_d.cnt   = '0;
                st_d.pend  = 1'b0;
            end else begin
                st_d.cnt = (st_q.cnt == last_bit) ? '0 : st_q.cnt + 1'b1;
                if (st_q.pend) st_d.remain = st_q.remain - 1'b1;
            end
        end

        if (fs_det) begin
            st_d.pend   = 1'b1;
            st_d.remain = delay;
            st_d.half   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample  = st_q.sample;
    assign launch  = st_q.launch;
    assign start   = st_q.start;
    assign bit_cnt = st_q.cnt;
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_ft_pkg::*;
#(
    parameter int OCT_W_P = OCT_W,
    localparam int CNT_W  = OCT_W_P + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_shared_pins,
    input  logic               cfg_launch_on_fall,
    input  logic               cfg_fs_on_rise,
    input  logic               cfg_fs_active_low,
    input  logic               cfg_double_rate,
    input  logic [1:0]         cfg_rx_fs_delay,
    input  logic [1:0]         cfg_tx_fs_delay,
    input  logic [OCT_W_P-1:0] cfg_frame_octets_m1,
    input  logic               rx_tdm_clk,
    input  logic               rx_tdm_fs,
    input  logic               tx_tdm_clk,
    input  logic               tx_tdm_fs,
    output logic               rx_sample,
    output logic               rx_launch,
    output logic               rx_frame_start,
    output logic [CNT_W-1:0]   rx_bit_cnt,
    output logic               tx_sample,
    output logic               tx_launch,
    output logic               tx_frame_start,
    output logic [CNT_W-1:0]   tx_bit_cnt
);
    localparam int NDIR = 2;

    logic [3:0]             pin_cur, pin_prev;
    logic [NDIR-1:0]        d_cur, d_prev, d_fs;
    logic [NDIR-1:0][1:0]   d_dly;
    logic [NDIR-1:0]        o_samp, o_launch, o_start;
    logic [NDIR-1:0][CNT_W-1:0] o_cnt;
    edge_cfg_t              ecfg;

    tdm_ft_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({tx_tdm_fs, tx_tdm_clk, rx_tdm_fs, rx_tdm_clk}),
        .cur   (pin_cur),
        .prev  (pin_prev)
    );

    always_comb begin
        ecfg.launch_fall = cfg_launch_on_fall;
        ecfg.fs_on_rise  = cfg_fs_on_rise;
        ecfg.fs_low      = cfg_fs_active_low;
        ecfg.dbl         = cfg_double_rate;
        d_cur[0]  = pin_cur[0];
        d_prev[0] = pin_prev[0];
        d_fs[0]   = pin_cur[1];
        d_cur[1]  = cfg_shared_pins ? pin_cur[0]  : pin_cur[2];
        d_prev[1] = cfg_shared_pins ? pin_prev[0] : pin_prev[2];
        d_fs[1]   = cfg_shared_pins ? pin_cur[1]  : pin_cur[3];
        d_dly[0]  = cfg_rx_fs_delay;
        d_dly[1]  = cfg_tx_fs_delay;
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        tdm_ft_dir #(.OCT_W_P(OCT_W_P)) u_dir (
            .clk       (clk),
            .rst_n     (rst_n),
            .ck_cur    (d_cur[g]),
            .ck_prev   (d_prev[g]),
            .fs_lvl    (d_fs[g]),
            .cfg       (ecfg),
            .delay     (d_dly[g]),
            .octets_m1 (cfg_frame_octets_m1),
            .sample    (o_samp[g]),
            .launch    (o_launch[g]),
            .start     (o_start[g]),
            .bit_cnt   (o_cnt[g])
        );
    end

    assign rx_sample      = o_samp[0];
    assign rx_launch      = o_launch[0];
    assign rx_frame_start = o_start[0];
    assign rx_bit_cnt     = o_cnt[0];
    assign tx_sample      = o_samp[1];
    assign tx_launch      = o_launch[1];
    assign tx_frame_start = o_start[1];
    assign tx_bit_cnt     = o_cnt[1];
endmodule

// File: rtl/tdm_ft_checker.sv
module tdm_ft_checker #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_sample,
    input logic             rx_launch,
    input logic             rx_frame_start,
    input logic [CNT_W-1:0] rx_bit_cnt,
    input logic             tx_sample,
    input logic             tx_launch,
    input logic             tx_frame_start,
    input logic [CNT_W-1:0] tx_bit_cnt
);
    a_r2_rx_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_sample && rx_launch));
    a_r2_tx_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_sample && tx_launch));
    a_r4_rx_start_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_start |-> rx_sample);
    a_r4_tx_start_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_start |-> tx_sample);
    a_r4_rx_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_start |=> !rx_frame_start);
    a_r5_rx_zero_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_start |-> rx_bit_cnt == '0);
    a_r5_tx_zero_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_start |-> tx_bit_cnt == '0);
    a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_sample |-> rx_bit_cnt == $past(rx_bit_cnt));
    a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sample |-> tx_bit_cnt == $past(tx_bit_cnt));
endmodule

bind tdm_frame_timer tdm_ft_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_sample      (rx_sample),
    .rx_launch      (rx_launch),
    .rx_frame_start (rx_frame_start),
    .rx_bit_cnt     (rx_bit_cnt),
    .tx_sample      (tx_sample),
    .tx_launch      (tx_launch),
    .tx_frame_start (tx_frame_start),
    .tx_bit_cnt     (tx_bit_cnt)
);

// File: tb/tb_tdm_frame_timer.sv
module tb_tdm_frame_timer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_shared = 0, m_lf = 0, m_fr = 0, m_low = 0, m_dbl = 0;
    logic [1:0] m_rdly = 0, m_tdly = 0;
    logic [5:0] m_oct = 0;
    logic rx_ck = 0, rx_fs = 0, tx_ck = 0, tx_fs = 0;
    logic rx_sample, rx_launch, rx_frame_start, tx_sample, tx_launch, tx_frame_start;
    logic [8:0] rx_bit_cnt, tx_bit_cnt;

    int checks = 0, failures = 0;
    bit cmp_en = 0, done = 0;
    string tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_frame_timer dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_shared_pins(m_shared), .cfg_launch_on_fall(m_lf),
        .cfg_fs_on_rise(m_fr), .cfg_fs_active_low(m_low),
        .cfg_double_rate(m_dbl), .cfg_rx_fs_delay(m_rdly),
        .cfg_tx_fs_delay(m_tdly), .cfg_frame_octets_m1(m_oct),
        .rx_tdm_clk(rx_ck), .rx_tdm_fs(rx_fs),
        .tx_tdm_clk(tx_ck), .tx_tdm_fs(tx_fs),
        .rx_sample(rx_sample), .rx_launch(rx_launch),
        .rx_frame_start(rx_frame_start), .rx_bit_cnt(rx_bit_cnt),
        .tx_sample(tx_sample), .tx_launch(tx_launch),
        .tx_frame_start(tx_frame_start), .tx_bit_cnt(tx_bit_cnt)
    );

    // Behavioural reference: pin history delayed as R2 states, then per-direction state
    int h1[4], h2[4], h3[4];
    int e_samp[2], e_lau[2], e_st[2], e_cnt[2];
    int r_half[2], r_pend[2], r_rem[2];
    int starts[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin h1[i] = 0; h2[i] = 0; h3[i] = 0; end
            for (int k = 0; k < 2; k++) begin
                e_samp[k] = 0; e_lau[k] = 0; e_st[k] = 0; e_cnt[k] = 0;
                r_half[k] = 0; r_pend[k] = 0; r_rem[k] = 0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                int ci, fi, now, was, lvl, up, dn, le, se, fe, det, lo, so, nh;
                ci  = (k == 1 && !m_shared) ? 2 : 0;
                fi  = ci + 1;
                now = h2[ci]; was = h3[ci]; lvl = h2[fi];
                up  = (now == 1 && was == 0) ? 1 : 0;
                dn  = (now == 0 && was == 1) ? 1 : 0;
                le  = m_lf ? dn : up;
                se  = m_lf ? up : dn;
                fe  = m_fr ? up : dn;
                det = (fe == 1 && lvl != int'(m_low)) ? 1 : 0;
                lo  = (le == 1 && (!m_dbl || r_half[k] == 0)) ? 1 : 0;
                so  = (se == 1 && (!m_dbl || r_half[k] == 1)) ? 1 : 0;
                nh  = m_dbl ? ((le == 1) ? 1 - r_half[k] : r_half[k]) : 0;
                e_lau[k] = lo; e_samp[k] = so; e_st[k] = 0;
                if (so == 1) begin
                    if (r_pend[k] == 1 && r_rem[k] == 0) begin
                        e_st[k] = 1; e_cnt[k] = 0; r_pend[k] = 0; starts[k]++;
                    end else begin
                        e_cnt[k] = (e_cnt[k] == 8 * (int'(m_oct) + 1) - 1) ? 0 : e_cnt[k] + 1;
                        if (r_pend[k] == 1) r_rem[k]--;
                    end
                end
                if (det == 1) begin
                    r_pend[k] = 1;
                    r_rem[k]  = (k == 0) ? int'(m_rdly) : int'(m_tdly);
                    nh = 0;
                end
                r_half[k] = nh;
            end
            for (int i = 0; i < 4; i++) begin h3[i] = h2[i]; h2[i] = h1[i]; end
            h1[0] = rx_ck; h1[1] = rx_fs; h1[2] = tx_ck; h1[3] = tx_fs;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s [%s] act=%0d exp=%0d at %0t", req, tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R2 rx_sample", int'(rx_sample), e_samp[0]);
            chk("R2 rx_launch", int'(rx_launch), e_lau[0]);
            chk("R4 rx_frame_start", int'(rx_frame_start), e_st[0]);
            chk("R5 rx_bit_cnt", int'(rx_bit_cnt), e_cnt[0]);
            chk("R2 tx_sample", int'(tx_sample), e_samp[1]);
            chk("R2 tx_launch", int'(tx_launch), e_lau[1]);
            chk("R4 tx_frame_start", int'(tx_frame_start), e_st[1]);
            chk("R5 tx_bit_cnt", int'(tx_bit_cnt), e_cnt[1]);
        end
    end

    task automatic drive_lane(input bit is_tx, input int half, input int nbits, input int every);
        for (int b = 0; b < nbits; b++) begin
            logic lvl;
            lvl = ((b % every) == 0) ? ~m_low : m_low;
            if (is_tx) begin tx_fs = lvl; tx_ck = 1'b1; end
            else       begin rx_fs = lvl; rx_ck = 1'b1; end
            repeat (half) @(negedge clk);
            if (is_tx) tx_ck = 1'b0; else rx_ck = 1'b0;
            repeat (half) @(negedge clk);
        end
    endtask

    task automatic run_case(input string t, input bit sh, input bit lf, input bit fr,
                            input bit low, input bit dbl, input int rd, input int td,
                            input int oct, input int nbits, input int rx_every,
                            input int tx_every, input int min_rx, input int max_rx,
                            input int min_tx);
        @(negedge clk);
        cmp_en = 0; rst_n = 0; tag = t;
        m_shared = sh; m_lf = lf; m_fr = fr; m_low = low; m_dbl = dbl;
        m_rdly = 2'(rd); m_tdly = 2'(td); m_oct = 6'(oct);
        rx_ck = 0; tx_ck = 0; rx_fs = low; tx_fs = low;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rx_sample", int'(rx_sample), 0);
        chk("R1 rx_frame_start", int'(rx_frame_start), 0);
        chk("R1 rx_bit_cnt", int'(rx_bit_cnt), 0);
        chk("R1 tx_launch", int'(tx_launch), 0);
        chk("R1 tx_bit_cnt", int'(tx_bit_cnt), 0);
        starts[0] = 0; starts[1] = 0;
        rst_n = 1; cmp_en = 1;
        fork
            drive_lane(1'b0, 4, nbits, rx_every);
            drive_lane(1'b1, sh ? 3 : 5, sh ? nbits * 2 : nbits, sh ? 2 : tx_every);
        join
        repeat (6) @(negedge clk);
        chk("R4 rx start count low bound", (starts[0] >= min_rx) ? 1 : 0, 1);
        chk("R8 rx start count high bound", (starts[0] <= max_rx) ? 1 : 0, 1);
        chk("R4 tx start count low bound", (starts[1] >= min_tx) ? 1 : 0, 1);
        cmp_en = 0;
    endtask

    initial begin
        // R2 R3 R4 R5: defaults, 8-bit frames, delay 0
        run_case("R3 default edges", 0, 0, 0, 0, 0, 0, 0, 0, 40, 8, 8, 3, 100, 3);
        // R2 R3: swapped edges, sync on rise, active low, delays 2 and 3, 16-bit frames
        run_case("R3 swapped low", 0, 1, 1, 1, 0, 2, 3, 1, 50, 16, 16, 2, 100, 2);
        // R8: syncs every third bit, rx delay 3 never completes, tx delay 1 does
        run_case("R8 restart", 0, 0, 1, 0, 0, 3, 1, 0, 30, 3, 3, 0, 0, 5);
        // R6 R7: double rate with shared pins, tx pins carry noise
        run_case("R6 R7 double shared", 1, 0, 0, 0, 1, 1, 0, 0, 64, 16, 2, 1, 100, 1);
        // R5: 64-octet frame runs past its wrap point with a single sync
        run_case("R5 long wrap", 0, 1, 0, 0, 0, 0, 2, 63, 560, 100000, 100000, 1, 1, 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog [%s] act=timeout exp=finish", tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule